// File: doc/BRIEF.md
# Paged Voice Register Host Interface

This block is the register file that a host processor sees in front of a multi-voice sample playback engine. The host uses a 4-bit address and a 16-bit data word. A 7-bit page register chooses what the lower addresses reach. They can reach the control words of one voice, the filter history words of one voice, or a shared bank that holds the channel output words and the serial output mode. Three addresses at the top of the map stay the same on every page. They hold the number of active voices, the pending interrupt vector and the page register itself.

Each access is taken on a rising edge of the host enable clock when the strobe is high. Read data appears on the next output register. Stored words keep only the bits that are implemented, and bits that are not implemented read back as ones. A second, independent port lets the voice datapath fetch any stored word of any voice. The same port also fetches the decoded control fields of a chosen voice and the value of a chosen output channel. The interrupt vector is loaded by the datapath through a set pulse, and a host read empties it.

Top module: `vrh_host_regs`

## Requirements
- R1: After synchronous reset, `acc_rdata` is 0xFFFF, the page is 0, the active count reads 31, the vector is empty, all serial mode bits are 0, and the channel words are 0.
- R2: Address 13 reads {11 ones, count}, address 14 reads the vector word, and address 15 reads {9 ones, page[6:0]}. A write to 15 loads the page from data[6:0]. These three addresses behave the same whatever the page holds.
- R3: A write to address 13 stores the larger of 7 and data[4:0], so the count never drops below 7.
- R4: The vector word is {8 ones, empty, 2 ones, voice[4:0]}, where the empty bit is 0 while a vector is pending. A pulse on `irq_set` makes `irq_voice` pending. A host read of address 14 returns the word and then empties it, so it reads 0xFFFF afterwards. If a set and a read happen in the same cycle, the set wins. Writes to address 14 are ignored.
- R5: When page bit 6 is 1, the shared channel/serial bank is selected. Otherwise page bit 5 selects the filter bank (1) or the control bank (0), and page bits 4:0 give the voice. The two banks of one voice are distinct storage.
- R6: In the control bank, the implemented bits per address are as follows. Address 0 keeps 11:0. Address 1 keeps 15:1. Addresses 2, 4 and 10 keep 12:0. Addresses 3, 5 and 11 keep 15:5. Addresses 6 and 7 keep 15:4. Addresses 8 and 9 keep 15:8. Address 12 keeps none. A read returns the stored bits, with ones in every bit that is not implemented.
- R7: In the filter bank, addresses 1 to 6 keep all 16 bits. Addresses 0 and 7 to 12 keep nothing and read 0xFFFF.
- R8: The control word is decoded as follows: stop in bits 1:0, sample bank in bit 2, loop enable in bit 3, bidirectional loop in bit 4, interrupt enable in bit 5, direction in bit 6, interrupt flag in bit 7, output channel in bits 9:8, filter mode in bits 11:10. The decoded fields of voice `dp_voice` appear on the `dp_*` field outputs one cycle after it is presented.
- R9: In the shared bank, addresses 0 to 7 hold channel words 0 to 3, with left at the even address and right at the odd address. They are written only while the serial test bit is 1. Host reads of channels 0 to 2 return 0xFFFF. Channel 3 returns its value only while the serial ADC bit is 1, and 0xFFFF otherwise.
- R10: Shared-bank address 8 holds the serial mode: ADC in bit 0, test in bit 1, alternate format in bit 2, and a 5-bit MSB field in bits 15:11. A read returns these bits with ones in bits 10:3. Shared-bank addresses 9 to 12 read 0xFFFF.
- R11: The data of a read with the strobe sampled at edge N is on `acc_rdata` after edge N. In a cycle with no strobe, `acc_rdata` holds its value and no register changes.
- R12: `dp_word` gives the stored, masked word at {`dp_filt`, `dp_voice`, `dp_addr`} one cycle later, without the ones fill. `dp_chan_l`/`dp_chan_r` give the words of channel `dp_chan` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host enable clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Host access strobe |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Host register address |
| acc_wdata | input | 16 | Host write data |
| acc_rdata | output | 16 | Registered host read data |
| irq_set | input | 1 | Loads a pending interrupt vector |
| irq_voice | input | 5 | Voice number for the vector |
| act_cnt | output | 5 | Active voice count |
| ser_adc | output | 1 | Serial ADC mode bit |
| ser_test | output | 1 | Serial test mode bit |
| ser_fmt | output | 1 | Alternate serial format bit |
| ser_msb | output | 5 | Serial MSB field |
| dp_voice | input | VW | Datapath voice select |
| dp_filt | input | 1 | Datapath bank select (1 = filter) |
| dp_addr | input | 4 | Datapath word select |
| dp_word | output | 16 | Stored word for the datapath |
| dp_stop | output | 2 | Decoded stop field |
| dp_bank | output | 1 | Decoded sample bank |
| dp_loop | output | 1 | Decoded loop enable |
| dp_bidir | output | 1 | Decoded bidirectional loop |
| dp_irqen | output | 1 | Decoded interrupt enable |
| dp_dir | output | 1 | Decoded direction |
| dp_irqf | output | 1 | Decoded interrupt flag |
| dp_chasg | output | 2 | Decoded output channel |
| dp_fmode | output | 2 | Decoded filter mode |
| dp_chan | input | 2 | Channel select for datapath view |
| dp_chan_l | output | 16 | Left word of selected channel |
| dp_chan_r | output | 16 | Right word of selected channel |

## Verification
The page register steers every lower address, so a single wrong page bit affects whole banks at once. A host read one cycle later then returns another voice's pattern, the other bank's pattern, or the shared-bank constants. A mask error shows on the very next read as a stored bit that should read one, or a kept bit that reads one. The vector logic only shows a fault on the read that follows a set or a clear. For that reason, reads are repeated back to back, and set and read are made to collide in one cycle.

// File: rtl/vrh_pkg.sv
package vrh_pkg;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int NCH = 4;

  localparam logic [AW-1:0] A_ACT  = 4'd13;
  localparam logic [AW-1:0] A_VEC  = 4'd14;
  localparam logic [AW-1:0] A_PAGE = 4'd15;
  localparam logic [AW-1:0] A_SER  = 4'd8;

  typedef struct packed {
    logic [1:0] fmode;
    logic [1:0] chasg;
    logic       irqf;
    logic       dir;
    logic       irqen;
    logic       bidir;
    logic       loop;
    logic       bank;
    logic [1:0] stop;
  } ctrl_t;

  function automatic logic [DW-1:0] word_mask(input logic filt, input logic [AW-1:0] a);
    logic [DW-1:0] m;
    if (filt) begin
      m = (a >= 4'd1 && a <= 4'd6) ? 16'hFFFF : 16'h0000;
    end else begin
      case (a)
        4'd0:                m = 16'h0FFF;
        4'd1:                m = 16'hFFFE;
        4'd2, 4'd4, 4'd10:   m = 16'h1FFF;
        4'd3, 4'd5, 4'd11:   m = 16'hFFE0;
        4'd6, 4'd7:          m = 16'hFFF0;
        4'd8, 4'd9:          m = 16'hFF00;
        default:             m = 16'h0000;
      endcase
    end
    return m;
  endfunction
endpackage

// File: rtl/vrh_voice_ram.sv
module vrh_voice_ram #(
  parameter int VOICES = 32,
  localparam int VW = (VOICES > 1) ? $clog2(VOICES) : 1,
  localparam int RAW = 1 + VW + vrh_pkg::AW,
  localparam int DEPTH = 2 * VOICES * 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic          h_filt,
  input  logic [VW-1:0] h_voice,
  input  logic [3:0]    h_addr,
  input  logic [15:0]   h_wdata,
  input  logic [15:0]   h_mask,
  output logic [15:0]   h_word,
  input  logic          dp_filt,
  input  logic [VW-1:0] dp_voice,
  input  logic [3:0]    dp_addr,
  output logic [15:0]   dp_word,
  output logic [11:0]   ctrl_word
);
  logic [15:0] mem [DEPTH];
  logic [RAW-1:0] h_idx, dp_idx, c_idx;

  assign h_idx  = {h_filt, h_voice, h_addr};
  assign dp_idx = {dp_filt, dp_voice, dp_addr};
  assign c_idx  = {1'b0, dp_voice, 4'd0};

  always_ff @(posedge clk) begin
    if (we) mem[h_idx] <= h_wdata & h_mask;
    dp_word <= mem[dp_idx];
  end

  logic [15:0] c_full;
  assign h_word    = mem[h_idx];
  assign c_full    = mem[c_idx];
  assign ctrl_word = c_full[11:0];
endmodule

// File: rtl/vrh_global_regs.sv
module vrh_global_regs
  import vrh_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        acc_en,
  input  logic        acc_we,
  input  logic [3:0]  acc_addr,
  input  logic [15:0] acc_wdata,
  input  logic        irq_set,
  input  logic [4:0]  irq_voice,
  input  logic [1:0]  dp_chan,
  output logic [6:0]  page,
  output logic [4:0]  act_cnt,
  output logic        ser_adc,
  output logic        ser_test,
  output logic        ser_fmt,
  output logic [4:0]  ser_msb,
  output logic        vec_pend,
  output logic        g_hit,
  output logic [15:0] g_rd,
  output logic [15:0] dp_chan_l,
  output logic [15:0] dp_chan_r,
  output logic [NCH*32-1:0] chan_flat
);
  logic [15:0] ch_l [NCH];
  logic [15:0] ch_r [NCH];
  logic [4:0]  vec_voice;
  logic        wr, rd;

  assign wr = acc_en & acc_we;
  assign rd = acc_en & ~acc_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      page <= '0;
      act_cnt <= 5'd31;
      ser_adc <= 1'b0;
      ser_test <= 1'b0;
      ser_fmt <= 1'b0;
      ser_msb <= '0;
      vec_pend <= 1'b0;
      vec_voice <= 5'h1F;
    end else begin
      if (wr && acc_addr == A_PAGE) page <= acc_wdata[6:0];
      if (wr && acc_addr == A_ACT)
        act_cnt <= (acc_wdata[4:0] < 5'd7) ? 5'd7 : acc_wdata[4:0];
      if (wr && page[6] && acc_addr == A_SER) begin
        ser_adc  <= acc_wdata[0];
        ser_test <= acc_wdata[1];
        ser_fmt  <= acc_wdata[2];
        ser_msb  <= acc_wdata[15:11];
      end
      if (irq_set) begin
        vec_pend  <= 1'b1;
        vec_voice <= irq_voice;
      end else if (rd && acc_addr == A_VEC) begin
        vec_pend  <= 1'b0;
        vec_voice <= 5'h1F;
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        ch_l[c] <= '0;
        ch_r[c] <= '0;
      end else if (wr && page[6] && ser_test && acc_addr < 4'd8 &&
                   acc_addr[2:1] == 2'(c)) begin
        if (acc_addr[0]) ch_r[c] <= acc_wdata;
        else             ch_l[c] <= acc_wdata;
      end
    end
    assign chan_flat[c*32 +: 32] = {ch_l[c], ch_r[c]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dp_chan_l <= '0;
      dp_chan_r <= '0;
    end else begin
      dp_chan_l <= ch_l[dp_chan];
      dp_chan_r <= ch_r[dp_chan];
    end
  end

  always_comb begin
    g_hit = 1'b0;
    g_rd  = 16'hFFFF;
    if (acc_addr >= A_ACT) begin
      g_hit = 1'b1;
      case (acc_addr)
        A_ACT:   g_rd = {11'h7FF, act_cnt};
        A_VEC:   g_rd = {8'hFF, ~vec_pend, 2'b11, vec_voice};
        default: g_rd = {9'h1FF, page};
      endcase
    end else if (page[6]) begin
      g_hit = 1'b1;
      if (acc_addr < 4'd8) begin
        if (acc_addr[2:1] == 2'd3 && ser_adc)
          g_rd = acc_addr[0] ? ch_r[3] : ch_l[3];
      end else if (acc_addr == A_SER) begin
        g_rd = {ser_msb, 8'hFF, ser_fmt, ser_test, ser_adc};
      end
    end
  end
endmodule

// File: rtl/vrh_ctrl_decode.sv
module vrh_ctrl_decode
  import vrh_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [11:0] word,
  output logic [1:0]  stop,
  output logic        bank,
  output logic        loop,
  output logic        bidir,
  output logic        irqen,
  output logic        dir,
  output logic        irqf,
  output logic [1:0]  chasg,
  output logic [1:0]  fmode
);
  ctrl_t f, q;
  assign f = ctrl_t'(word);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= f;
  end

  assign stop  = q.stop;
  assign bank  = q.bank;
  assign loop  = q.loop;
  assign bidir = q.bidir;
  assign irqen = q.irqen;
  assign dir   = q.dir;
  assign irqf  = q.irqf;
  assign chasg = q.chasg;
  assign fmode = q.fmode;
endmodule

// File: rtl/vrh_host_regs.sv
module vrh_host_regs
  import vrh_pkg::*;
#(
  parameter int VOICES = 32,
  localparam int VW = (VOICES > 1) ? $clog2(VOICES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_en,
  input  logic          acc_we,
  input  logic [3:0]    acc_addr,
  input  logic [15:0]   acc_wdata,
  output logic [15:0]   acc_rdata,
  input  logic          irq_set,
  input  logic [4:0]    irq_voice,
  output logic [4:0]    act_cnt,
  output logic          ser_adc,
  output logic          ser_test,
  output logic          ser_fmt,
  output logic [4:0]    ser_msb,
  input  logic [VW-1:0] dp_voice,
  input  logic          dp_filt,
  input  logic [3:0]    dp_addr,
  output logic [15:0]   dp_word,
  output logic [1:0]    dp_stop,
  output logic          dp_bank,
  output logic          dp_loop,
  output logic          dp_bidir,
  output logic          dp_irqen,
  output logic          dp_dir,
  output logic          dp_irqf,
  output logic [1:0]    dp_chasg,
  output logic [1:0]    dp_fmode,
  input  logic [1:0]    dp_chan,
  output logic [15:0]   dp_chan_l,
  output logic [15:0]   dp_chan_r
);
  logic [6:0]  page_q;
  logic        vec_pend;
  logic        g_hit;
  logic [15:0] g_rd;
  logic [15:0] v_word, v_mask;
  logic [11:0] ctrl_word;
  logic        v_we;
  logic [NCH*32-1:0] chan_flat;

  vrh_global_regs i_glob (
    .clk, .rst, .acc_en, .acc_we, .acc_addr, .acc_wdata,
    .irq_set, .irq_voice, .dp_chan,
    .page(page_q), .act_cnt, .ser_adc, .ser_test, .ser_fmt, .ser_msb,
    .vec_pend, .g_hit, .g_rd, .dp_chan_l, .dp_chan_r, .chan_flat
  );

  assign v_mask = word_mask(page_q[5], acc_addr);
  assign v_we   = acc_en & acc_we & ~page_q[6] & (acc_addr < A_ACT);

  vrh_voice_ram #(.VOICES(VOICES)) i_ram (
    .clk, .we(v_we), .h_filt(page_q[5]), .h_voice(page_q[VW-1:0]),
    .h_addr(acc_addr), .h_wdata(acc_wdata), .h_mask(v_mask), .h_word(v_word),
    .dp_filt, .dp_voice, .dp_addr, .dp_word, .ctrl_word
  );

  vrh_ctrl_decode i_dec (
    .clk, .rst, .word(ctrl_word),
    .stop(dp_stop), .bank(dp_bank), .loop(dp_loop), .bidir(dp_bidir),
    .irqen(dp_irqen), .dir(dp_dir), .irqf(dp_irqf),
    .chasg(dp_chasg), .fmode(dp_fmode)
  );

  always_ff @(posedge clk) begin
    if (rst) acc_rdata <= 16'hFFFF;
    else if (acc_en && !acc_we)
      acc_rdata <= g_hit ? g_rd : (v_word | ~v_mask);
  end
endmodule

// File: rtl/vrh_host_regs_chk.sv
module vrh_host_regs_chk (
  input logic        clk,
  input logic        rst,
  input logic        acc_en,
  input logic        acc_we,
  input logic [3:0]  acc_addr,
  input logic [15:0] acc_wdata,
  input logic [15:0] acc_rdata,
  input logic        irq_set,
  input logic [4:0]  act_cnt,
  input logic [6:0]  page_q,
  input logic        vec_pend,
  input logic        ser_test,
  input logic [127:0] chan_flat
);
  p_act_floor_r3: assert property (@(posedge clk) disable iff (rst)
    act_cnt >= 5'd7);

  p_act_write_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_we && acc_addr == 4'd13) |=>
      act_cnt == (($past(acc_wdata[4:0]) < 5'd7) ? 5'd7 : $past(acc_wdata[4:0])));

  p_page_write_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_we && acc_addr == 4'd15) |=> page_q == $past(acc_wdata[6:0]));

  p_vec_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_we && acc_addr == 4'd14 && !irq_set) |=> !vec_pend);

  p_vec_set_r4: assert property (@(posedge clk) disable iff (rst)
    irq_set |=> vec_pend);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> $stable(acc_rdata));

  p_chan_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_we && page_q[6] && !ser_test) |=> $stable(chan_flat));
endmodule

bind vrh_host_regs vrh_host_regs_chk i_chk (
  .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr),
  .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .irq_set(irq_set),
  .act_cnt(act_cnt), .page_q(page_q), .vec_pend(vec_pend),
  .ser_test(ser_test), .chan_flat(chan_flat)
);

// File: tb/test_vrh_host_regs.sv
module test_vrh_host_regs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_en = 0, acc_we = 0;
  logic [3:0] acc_addr = 0;
  logic [15:0] acc_wdata = 0;
  logic [15:0] acc_rdata;
  logic irq_set = 0;
  logic [4:0] irq_voice = 0;
  logic [4:0] act_cnt, ser_msb;
  logic ser_adc, ser_test, ser_fmt;
  logic [4:0] dp_voice = 0;
  logic dp_filt = 0;
  logic [3:0] dp_addr = 0;
  logic [15:0] dp_word, dp_chan_l, dp_chan_r;
  logic [1:0] dp_stop, dp_chasg, dp_fmode, dp_chan = 0;
  logic dp_bank, dp_loop, dp_bidir, dp_irqen, dp_dir, dp_irqf;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vrh_host_regs i_vrh_host_regs (
    .clk, .rst, .acc_en, .acc_we, .acc_addr, .acc_wdata, .acc_rdata,
    .irq_set, .irq_voice, .act_cnt, .ser_adc, .ser_test, .ser_fmt, .ser_msb,
    .dp_voice, .dp_filt, .dp_addr, .dp_word, .dp_stop, .dp_bank, .dp_loop,
    .dp_bidir, .dp_irqen, .dp_dir, .dp_irqf, .dp_chasg, .dp_fmode,
    .dp_chan, .dp_chan_l, .dp_chan_r
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    acc_en = 1; acc_we = 1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 0; acc_we = 0;
  endtask

  task automatic hr(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    acc_en = 1; acc_we = 0; acc_addr = a;
    @(negedge clk);
    acc_en = 0;
    d = acc_rdata;
  endtask

  function automatic logic [15:0] emask(input logic f, input int a);
    if (f) return (a >= 1 && a <= 6) ? 16'hFFFF : 16'h0000;
    case (a)
      0: return 16'h0FFF;
      1: return 16'hFFFE;
      2, 4, 10: return 16'h1FFF;
      3, 5, 11: return 16'hFFE0;
      6, 7: return 16'hFFF0;
      8, 9: return 16'hFF00;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] pat(input logic f, input int v, input int a);
    logic [15:0] x;
    x = 16'(v * 4951) ^ 16'(a * 3869) ^ (f ? 16'h3C5A : 16'hA5C3);
    return x;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 rdata", acc_rdata, 16'hFFFF);
    chk("R1 act", {11'd0, act_cnt}, 16'd31);
    chk("R1 ser", {10'd0, ser_msb, ser_adc}, 16'd0);
    hr(4'd15, r); chk("R1 page", r, 16'hFF80);
    hr(4'd14, r); chk("R1 vec", r, 16'hFFFF);
    hr(4'd13, r); chk("R2 act read", r, 16'hFFFF);

    // R3 sweep of active count
    for (int v = 0; v < 32; v++) begin
      hw(4'd13, 16'hA5E0 | 16'(v));
      hr(4'd13, r);
      chk("R3 act", r, 16'hFFE0 | 16'((v < 7) ? 7 : v));
    end

    // R2 page and globals on shared page
    hw(4'd15, 16'hFF35); hr(4'd15, r); chk("R2 page", r, 16'hFFB5);
    hw(4'd15, 16'h0040); hw(4'd13, 16'd12);
    hr(4'd13, r); chk("R2 act on shared page", r, 16'hFFEC);

    // R4 vector
    @(negedge clk); irq_set = 1; irq_voice = 5'd9;
    @(negedge clk); irq_set = 0;
    hw(4'd14, 16'h0000);
    hr(4'd14, r); chk("R4 pending", r, 16'hFF69);
    hr(4'd14, r); chk("R4 cleared", r, 16'hFFFF);
    @(negedge clk); irq_set = 1; irq_voice = 5'd4;
    @(negedge clk); irq_voice = 5'd2;
    acc_en = 1; acc_we = 0; acc_addr = 4'd14;
    @(negedge clk); irq_set = 0; acc_en = 0;
    chk("R4 collide read", acc_rdata, 16'hFF64);
    hr(4'd14, r); chk("R4 set wins", r, 16'hFF62);
    hr(4'd14, r); chk("R4 empty", r, 16'hFFFF);

    // R10 serial mode
    hw(4'd8, 16'h5805);
    hr(4'd8, r); chk("R10 ser read", r, 16'h5FFD);
    chk("R10 ser ports", {8'd0, ser_msb, ser_fmt, ser_test, ser_adc}, 16'h005D);
    for (int a = 9; a < 13; a++) begin
      hr(4'(a), r); chk("R10 shared unused", r, 16'hFFFF);
    end

    // R9 channel gating
    hw(4'd8, 16'h0001);
    hw(4'd6, 16'h1234);
    hr(4'd6, r); chk("R9 ignored write", r, 16'h0000);
    hw(4'd8, 16'h0003);
    hw(4'd6, 16'h1234); hw(4'd7, 16'hBEEF); hw(4'd0, 16'h4444); hw(4'd3, 16'h5151);
    hr(4'd6, r); chk("R9 ch3 left", r, 16'h1234);
    hr(4'd7, r); chk("R9 ch3 right", r, 16'hBEEF);
    hr(4'd0, r); chk("R9 ch0 blocked", r, 16'hFFFF);
    hr(4'd3, r); chk("R9 ch1 blocked", r, 16'hFFFF);
    hw(4'd8, 16'h0002);
    hr(4'd6, r); chk("R9 ch3 no adc", r, 16'hFFFF);
    @(negedge clk); dp_chan = 2'd0;
    @(negedge clk); chk("R12 chan0 l", dp_chan_l, 16'h4444);
    dp_chan = 2'd1;
    @(negedge clk); chk("R12 chan1 r", dp_chan_r, 16'h5151);
    hw(4'd8, 16'h0000);

    // R6/R7/R5 bank sweeps
    for (int f = 0; f < 2; f++)
      for (int v = 0; v < 32; v++) begin
        hw(4'd15, 16'(f * 32 + v));
        for (int a = 0; a < 13; a++) hw(4'(a), pat(f[0], v, a));
      end
    for (int f = 0; f < 2; f++)
      for (int v = 0; v < 32; v++) begin
        hw(4'd15, 16'(f * 32 + v));
        for (int a = 0; a < 13; a++) begin
          hr(4'(a), r);
          chk(f ? "R7 R5 filter word" : "R6 R5 control word", r,
              (pat(f[0], v, a) & emask(f[0], a)) | ~emask(f[0], a));
        end
      end

    // R11 idle hold
    hw(4'd15, 16'd3); hr(4'd1, r);
    repeat (3) @(negedge clk);
    chk("R11 idle hold", acc_rdata, (pat(1'b0, 3, 1) & 16'hFFFE) | 16'h0001);

    // R12 datapath word port
    @(negedge clk); dp_filt = 1; dp_voice = 5'd17; dp_addr = 4'd4;
    @(negedge clk); chk("R12 dp filter", dp_word, pat(1'b1, 17, 4));
    dp_filt = 0; dp_voice = 5'd8; dp_addr = 4'd3;
    @(negedge clk); chk("R12 dp ctrl bank", dp_word, pat(1'b0, 8, 3) & 16'hFFE0);

    // R8 control decode
    hw(4'd15, 16'd5); hw(4'd0, 16'hFABC);
    @(negedge clk); dp_voice = 5'd5;
    @(negedge clk);
    chk("R8 fields A", {dp_fmode, dp_chasg, dp_irqf, dp_dir, dp_irqen, dp_bidir,
                         dp_loop, dp_bank, dp_stop}, 16'h0ABC);
    hw(4'd0, 16'h05F3);
    @(negedge clk);
    chk("R8 stop", {14'd0, dp_stop}, 16'd3);
    chk("R8 chasg", {14'd0, dp_chasg}, 16'd1);
    chk("R8 fmode", {14'd0, dp_fmode}, 16'd1);
    chk("R8 flags", {10'd0, dp_irqf, dp_dir, dp_irqen, dp_bidir, dp_loop, dp_bank}, 16'h003C);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule